// File: doc/BRIEF.md
# Image Source Burst Reader

This block fetches a contiguous image from memory over the read channels of an AXI4 bus and hands every 64-bit data beat it receives to a downstream buffer FIFO of 256 entries. A one-cycle start command loads a base address, an image width and an image height in pixels. The amount to move is two bytes per pixel, rounded up to whole 8-byte beats. The block then issues incrementing bursts on the read-address channel, one at a time, and writes each returned beat into the FIFO through a simple write port.

The FIFO reports how many entries are free. Before it issues a burst, the reader checks that this free count, less the beats already granted but not yet written, covers the whole burst. A slow consumer downstream therefore stalls the fetch, and data is never lost. A done pulse follows the final beat, and an error flag reports whether any beat came back with a non-OKAY response.

Top module: `img_burst_reader`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs arvalid, fifo_wr_en, busy, done and err are all 0, and rready is 0 while reset is high.
- R2: The image spans ceil(width*height*2/8) beats. Each accepted R beat appears on fifo_wr_data with fifo_wr_en high on the cycle after its handshake, with its data unchanged and in arrival order.
- R3: Every read burst has arburst = 2'b01 (INCR), arsize = 3'b011 (8 bytes) and arlen at most 15 (1 to 16 beats).
- R4: The first burst starts at the base address with its low three bits forced to zero. Each later burst starts at the byte just after the previous one. No burst crosses a 4096-byte address boundary.
- R5: A burst is requested only when fifo_free is at least the burst length plus the beats already requested but not yet written. The FIFO is therefore never written while it is full.
- R6: At most one burst is outstanding. No new arvalid appears until the RLAST beat of the current burst has been accepted.
- R7: Once arvalid is raised, it stays high with araddr and arlen unchanged until arready is seen.
- R8: busy rises on the cycle after an accepted start. done is a one-cycle pulse on the cycle after the final RLAST handshake, which is the same cycle as the last FIFO write. busy falls on that same cycle.
- R9: An R beat whose rresp is not 2'b00 (OKAY) sets err. err stays set through done and is cleared only by the next accepted start.
- R10: A start while busy is high is ignored. A start for an image of zero pixels issues no burst and pulses done on the next cycle, with busy staying low and err low.
- R11: rready is high on every cycle from the second cycle after reset falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command to begin a fetch |
| src_addr | input | 32 | Base byte address of the image |
| img_width | input | 16 | Image width in pixels |
| img_height | input | 16 | Image height in pixels |
| fifo_free | input | 9 | Free entries in the downstream FIFO (0 to 256) |
| arvalid | output | 1 | Read-address valid |
| arready | input | 1 | Read-address ready |
| araddr | output | 32 | Burst start byte address |
| arlen | output | 8 | Beats in burst minus one |
| arsize | output | 3 | Beat size code, fixed at 8 bytes |
| arburst | output | 2 | Burst type, fixed at INCR |
| rvalid | input | 1 | Read-data valid |
| rdata | input | 64 | Read data beat |
| rresp | input | 2 | Read response |
| rlast | input | 1 | Final beat of the burst |
| rready | output | 1 | Read-data ready |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 64 | FIFO write data |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky error from any non-OKAY response |

## Verification
Two pairs of events can fall on the same cycle. The FIFO write of the last beat of a burst lands on the very cycle in which the reader decides whether it may request the next burst. On the final burst, that last write coincides with done and with busy falling. The bench provokes the first case by stalling the modelled consumer while a 1024-beat image is in flight, so the free count settles right at the edge of a 16-beat grant. The model then judges every write against the occupancy it tracks and compares the data against a queue of expected words. The second case is judged by sampling done, busy and the write strobe on the cycle after the final RLAST handshake, including runs that insert gaps between beats and stalls on arready.

// File: rtl/img_rd_pkg.sv
package img_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PLAN, ST_ADDR, ST_DATA} rd_state_e;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/rd_burst_sizer.sv
// Picks the next burst length: the smallest of the burst cap, the beats
// left to the next address boundary and the beats left in the image.
module rd_burst_sizer #(
  parameter int MAX_BURST  = 16,
  parameter int BEAT_BYTES = 8,
  parameter int BOUNDARY   = 4096,
  parameter int CNT_W      = 34,
  localparam int SIZE_CODE  = $clog2(BEAT_BYTES),
  localparam int OFF_W      = $clog2(BOUNDARY),
  localparam int PAGE_BEATS = BOUNDARY / BEAT_BYTES,
  localparam int PAGE_W     = $clog2(PAGE_BEATS + 1),
  localparam int LEN_W      = $clog2(MAX_BURST + 1)
) (
  input  logic [OFF_W-1:SIZE_CODE] page_addr,
  input  logic [CNT_W-1:0]         beats_left,
  output logic [LEN_W-1:0]         burst_len
);
  logic [PAGE_W-1:0] to_page;
  logic [CNT_W-1:0]  pick;

  assign to_page = PAGE_W'(PAGE_BEATS) - PAGE_W'(page_addr);

  always_comb begin
    pick = CNT_W'(MAX_BURST);
    if (CNT_W'(to_page) < pick) pick = CNT_W'(to_page);
    if (beats_left < pick)      pick = beats_left;
  end

  assign burst_len = LEN_W'(pick);
endmodule

// File: rtl/rd_space_gate.sv
// Tracks beats granted on AR but not yet written into the FIFO and
// decides whether the free space covers one more burst.
module rd_space_gate #(
  parameter int FIFO_DEPTH = 256,
  parameter int MAX_BURST  = 16,
  localparam int FREE_W = $clog2(FIFO_DEPTH + 1),
  localparam int LEN_W  = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic [LEN_W-1:0]  want_len,
  input  logic              issue,
  input  logic [LEN_W-1:0]  issue_len,
  input  logic              wr_beat,
  output logic              room
);
  logic [FREE_W-1:0] owed_q;

  always_ff @(posedge clk) begin
    if (rst) owed_q <= '0;
    else     owed_q <= owed_q + (issue ? FREE_W'(issue_len) : '0)
                             - (wr_beat ? FREE_W'(1) : '0);
  end

  assign room = {1'b0, fifo_free} >= ({1'b0, owed_q} + (FREE_W+1)'(want_len));

  // R5: every FIFO write consumes a slot reserved by an earlier grant
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    wr_beat |-> owed_q != '0)
    else $error("write without reserved slot");

  // R5: reservations never exceed the FIFO capacity
  assert_owed_bound_R5: assert property (@(posedge clk) disable iff (rst)
    owed_q <= FREE_W'(FIFO_DEPTH))
    else $error("reservation above depth");
endmodule

// File: rtl/rd_beat_sink.sv
// Registers each accepted beat onto the FIFO write port and keeps the
// sticky response error.
module rd_beat_sink
  import img_rd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_fire,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [1:0]        beat_resp,
  input  logic              err_clear,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              err_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      wr_en <= beat_fire;
      if (err_clear)                              err_flag <= 1'b0;
      else if (beat_fire && beat_resp != RESP_OKAY) err_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (beat_fire) wr_data <= beat_data;
  end

  // R2: a beat reaches the FIFO port one cycle after its handshake
  assert_beat_latency_R2: assert property (@(posedge clk) disable iff (rst)
    beat_fire |=> wr_en && wr_data == $past(beat_data))
    else $error("beat not forwarded");

  // R9: the error stays set until a new fetch is accepted
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err_flag && !err_clear |=> err_flag)
    else $error("error flag dropped");
endmodule

// File: rtl/img_burst_reader.sv
module img_burst_reader
  import img_rd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int DIM_W      = 16,
  parameter int PX_LOG2    = 1,
  parameter int FIFO_DEPTH = 256,
  parameter int MAX_BURST  = 16,
  parameter int BOUNDARY   = 4096,
  localparam int FREE_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [DIM_W-1:0]  img_width,
  input  logic [DIM_W-1:0]  img_height,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rlast,
  output logic              rready,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int SIZE_CODE  = $clog2(BEAT_BYTES);
  localparam int OFF_W      = $clog2(BOUNDARY);
  localparam int LEN_W      = $clog2(MAX_BURST + 1);
  localparam int CNT_W      = 2 * DIM_W + PX_LOG2 + 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(BEAT_BYTES - 1);

  rd_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [LEN_W-1:0]  cur_len_q;
  logic [CNT_W-1:0]  img_bytes, img_beats;
  logic [LEN_W-1:0]  next_len;
  logic              room, beat_fire, take_start;

  assign img_bytes  = (CNT_W'(img_width) * CNT_W'(img_height)) << PX_LOG2;
  assign img_beats  = (img_bytes + CNT_W'(BEAT_BYTES - 1)) >> SIZE_CODE;
  assign beat_fire  = rvalid && rready;
  assign take_start = start && state_q == ST_IDLE;
  assign arsize     = 3'(SIZE_CODE);
  assign arburst    = BURST_INCR;

  rd_burst_sizer #(.MAX_BURST(MAX_BURST), .BEAT_BYTES(BEAT_BYTES),
                   .BOUNDARY(BOUNDARY), .CNT_W(CNT_W)) u_sizer (
    .page_addr (addr_q[OFF_W-1:SIZE_CODE]),
    .beats_left(left_q),
    .burst_len (next_len)
  );

  rd_space_gate #(.FIFO_DEPTH(FIFO_DEPTH), .MAX_BURST(MAX_BURST)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .fifo_free(fifo_free),
    .want_len (next_len),
    .issue    (arvalid && arready),
    .issue_len(cur_len_q),
    .wr_beat  (fifo_wr_en),
    .room     (room)
  );

  rd_beat_sink #(.DATA_W(DATA_W)) u_sink (
    .clk      (clk),
    .rst      (rst),
    .beat_fire(beat_fire),
    .beat_data(rdata),
    .beat_resp(rresp),
    .err_clear(take_start),
    .wr_en    (fifo_wr_en),
    .wr_data  (fifo_wr_data),
    .err_flag (err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      left_q    <= '0;
      cur_len_q <= '0;
      arvalid   <= 1'b0;
      araddr    <= '0;
      arlen     <= '0;
      rready    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      rready <= 1'b1;
      done   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          addr_q <= src_addr & ~ALIGN_MASK;
          left_q <= img_beats;
          if (img_beats == '0) done <= 1'b1;
          else begin
            busy    <= 1'b1;
            state_q <= ST_PLAN;
          end
        end
        ST_PLAN: if (room) begin
          arvalid   <= 1'b1;
          araddr    <= addr_q;
          arlen     <= 8'(next_len) - 8'd1;
          cur_len_q <= next_len;
          state_q   <= ST_ADDR;
        end
        ST_ADDR: if (arready) begin
          arvalid <= 1'b0;
          state_q <= ST_DATA;
        end
        ST_DATA: if (beat_fire && rlast) begin
          addr_q <= addr_q + (ADDR_W'(cur_len_q) << SIZE_CODE);
          left_q <= left_q - CNT_W'(cur_len_q);
          if (left_q == CNT_W'(cur_len_q)) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PLAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: burst length cap
  assert_burst_len_R3: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> arlen < 8'(MAX_BURST))
    else $error("burst too long");

  // R4: a burst stays inside one address page
  assert_no_page_cross_R4: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> ((OFF_W+1)'(araddr[OFF_W-1:0])
                 + (((OFF_W+1)'(arlen) + (OFF_W+1)'(1)) << SIZE_CODE))
                <= (OFF_W+1)'(BOUNDARY))
    else $error("burst crosses page");

  // R5: the FIFO has a free entry whenever it is written
  assert_fifo_room_R5: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> fifo_free != '0)
    else $error("write into full FIFO");

  // R6: no address request while data of a burst is flowing
  assert_single_burst_R6: assert property (@(posedge clk) disable iff (rst)
    beat_fire |-> !arvalid)
    else $error("overlapping bursts");

  // R7: request held until accepted
  assert_ar_hold_R7: assert property (@(posedge clk) disable iff (rst)
    arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen))
    else $error("request changed before accept");

  // R8: done is a single-cycle pulse with busy already low
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done longer than one cycle");
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy)
    else $error("done while busy");
endmodule

// File: tb/img_burst_reader_tb_top.sv
module img_burst_reader_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] src_addr = '0;
  logic [15:0] img_width = '0, img_height = '0;
  logic [8:0]  fifo_free = 9'(DEPTH);
  logic        arvalid, arready, rvalid, rlast, rready;
  logic [31:0] araddr;
  logic [7:0]  arlen;
  logic [2:0]  arsize;
  logic [1:0]  arburst, rresp;
  logic [63:0] rdata, fifo_wr_data;
  logic        fifo_wr_en, busy, done, err;

  always #10 clk = ~clk;

  img_burst_reader dut_i (
    .clk(clk), .rst(rst), .start(start), .src_addr(src_addr),
    .img_width(img_width), .img_height(img_height), .fifo_free(fifo_free),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .arsize(arsize), .arburst(arburst), .rvalid(rvalid), .rdata(rdata),
    .rresp(rresp), .rlast(rlast), .rready(rready), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .busy(busy), .done(done), .err(err)
  );

  int checks = 0, fails = 0;
  logic [63:0] exp_q[$];
  int drain_mode = 1, ar_delay = 0, err_beat = -1, total_exp = 0, done_cnt = 0;
  bit gaps = 0, live = 0;
  logic [31:0] exp_ar_addr = '0;

  function automatic logic [63:0] mem_word(logic [31:0] a);
    return {~a, a};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Memory-side responder: AR acceptance and R beats
  initial begin
    bit ar_fire = 0, r_fire = 0, ar_hold = 0;
    logic [31:0] cap_addr = '0, hold_addr = '0, burst_addr = '0;
    logic [7:0] cap_len = '0;
    logic [2:0] cap_size = '0;
    logic [1:0] cap_burst = '0;
    int ar_wait = 0, burst_left = 0, burst_pos = 0, beat_idx = 0, cyc = 0;
    arready = 0; rvalid = 0; rdata = '0; rresp = '0; rlast = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!live) begin beat_idx = 0; end
      if (r_fire) begin
        burst_left--; burst_pos++; beat_idx++;
        if (beat_idx == total_exp)
          check(done === 1'b1 && fifo_wr_en === 1'b1 && busy === 1'b0, "R8",
                "done/wr/busy after final beat", {done, fifo_wr_en, busy}, 3'b110);
      end
      if (ar_hold)
        check(arvalid === 1'b1 && araddr === hold_addr, "R7", "request held",
              araddr, hold_addr);
      if (ar_fire) begin
        check(burst_left == 0, "R6", "burst overlaps previous", 64'(burst_left), 0);
        check(cap_burst == 2'b01 && cap_size == 3'b011, "R3", "burst type/size",
              {cap_burst, cap_size}, 5'b01011);
        check(cap_len <= 8'd15, "R3", "arlen", cap_len, 15);
        check(cap_addr == exp_ar_addr, "R4", "burst address", cap_addr, exp_ar_addr);
        check(int'(cap_addr[11:0]) + (int'(cap_len) + 1) * 8 <= 4096, "R4",
              "page crossing", cap_addr, exp_ar_addr);
        burst_left = int'(cap_len) + 1; burst_pos = 0; burst_addr = cap_addr;
        exp_ar_addr = cap_addr + 32'((int'(cap_len) + 1) * 8);
        arready = 0; ar_wait = 0;
      end
      if (arvalid === 1'b1 && !arready) begin
        if (ar_wait >= ar_delay) arready = 1;
        else ar_wait++;
      end
      ar_hold = arvalid === 1'b1 && !arready;
      hold_addr = araddr;
      ar_fire = arvalid === 1'b1 && arready;
      if (ar_fire) begin
        cap_addr = araddr; cap_len = arlen; cap_size = arsize; cap_burst = arburst;
      end
      if (burst_left > 0 && !(gaps && (cyc % 4) == 2)) begin
        rvalid = 1;
        rdata = mem_word(burst_addr + 32'(burst_pos * 8));
        rlast = burst_left == 1;
        rresp = (beat_idx == err_beat) ? 2'b10 : 2'b00;
      end else begin
        rvalid = 0; rlast = 0; rresp = 2'b00;
      end
      r_fire = rvalid && rready === 1'b1;
    end
  end

  // FIFO model and scoreboard monitor
  initial begin
    int occ = 0, dcyc = 0;
    bit pwr = 0, prd = 0, dec;
    logic [63:0] expv;
    forever begin
      @(negedge clk);
      dcyc++;
      if (pwr) check(occ < DEPTH, "R5", "write into full FIFO", 64'(occ), DEPTH - 1);
      occ = occ + int'(pwr) - int'(prd);
      if (done === 1'b1) done_cnt++;
      pwr = fifo_wr_en === 1'b1;
      if (pwr) begin
        if (exp_q.size() == 0) check(0, "R2", "unexpected beat", fifo_wr_data, 0);
        else begin
          expv = exp_q.pop_front();
          check(fifo_wr_data === expv, "R2", "beat data", fifo_wr_data, expv);
        end
      end
      case (drain_mode)
        0: dec = 0;
        1: dec = 1;
        default: dec = (dcyc % 3) != 0;
      endcase
      prd = dec && occ > 0;
      fifo_free = 9'(DEPTH - occ);
    end
  end

  task automatic run_img(logic [31:0] base, int w, int h, int errb, bit want_err);
    int nb;
    logic [31:0] al;
    nb = (w * h * 2 + 7) / 8;
    al = base & ~32'h7;
    for (int i = 0; i < nb; i++) exp_q.push_back(mem_word(al + 32'(i * 8)));
    exp_ar_addr = al; err_beat = errb; total_exp = nb; done_cnt = 0;
    @(negedge clk);
    live = 1;
    start = 1; src_addr = base; img_width = 16'(w); img_height = 16'(h);
    @(negedge clk);
    start = 0;
    if (nb > 0) check(busy === 1'b1, "R8", "busy after start", busy, 1);
    else check(done === 1'b1 && busy === 1'b0 && arvalid === 1'b0, "R10",
               "empty image done", {done, busy, arvalid}, 3'b100);
    for (int t = 0; t < 20000 && done_cnt == 0; t++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(done_cnt == 1, "R8", "done pulse count", 64'(done_cnt), 1);
    check(exp_q.size() == 0, "R2", "beats missing", 64'(exp_q.size()), 0);
    check(err === want_err, "R9", "error flag at end", err, 64'(want_err));
    check(busy === 1'b0 && arvalid === 1'b0, "R8", "idle after done", {busy, arvalid}, 0);
    exp_q.delete();
    live = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({arvalid, fifo_wr_en, busy, done, err, rready} === 6'b0, "R1",
          "outputs in reset", {arvalid, fifo_wr_en, busy, done, err, rready}, 0);
    rst = 0;
    @(negedge clk);
    check({arvalid, fifo_wr_en, busy, done, err} === 5'b0, "R1",
          "outputs after reset", {arvalid, fifo_wr_en, busy, done, err}, 0);
    check(rready === 1'b1, "R11", "rready after reset", rready, 1);

    run_img(32'h6000_0000, 8, 4, -1, 0);               // 8 beats
    ar_delay = 2; gaps = 1;
    run_img(32'h6000_0105, 3, 3, -1, 0);               // R4 alignment, 3 beats
    run_img(32'h6000_0FC0, 40, 2, -1, 0);              // R4 split 8 + 12
    ar_delay = 1;
    run_img(32'h6100_0000, 16, 4, 5, 1);               // R9 error on beat 5
    run_img(32'h6100_0800, 8, 2, -1, 0);               // R9 cleared by start
    run_img(32'h6100_0000, 0, 7, -1, 0);               // R10 empty image
    check(rready === 1'b1, "R11", "rready held", rready, 1);

    // R5/R10: stalled consumer, 1024 beats, start while busy ignored
    drain_mode = 0; ar_delay = 0; gaps = 0;
    fork
      begin
        repeat (40) @(negedge clk);
        start = 1; src_addr = 32'h6300_0000; img_width = 16'd2; img_height = 16'd2;
        @(negedge clk);
        start = 0;
        repeat (700) @(negedge clk);
        drain_mode = 2;
      end
    join_none
    run_img(32'h6000_2F88, 64, 64, -1, 0);
    finish_run();
  end
endmodule